// File: doc/BRIEF.md
# Multi-Channel Compare Match Timer

A memory-mapped timer with a parameterised number of 32-bit up-counting channels. It lives in a fast bus clock domain. A slow, asynchronous reference clock is brought in through a synchroniser, and its rising edges drive one shared free-running prescaler. Each channel picks a count rate from that prescaler: the undivided reference rate, or division by 8, 32 or 128. A single run register holds one enable bit per channel.

Every channel has three registers: a control/status word, a counter and a compare value. When the counter equals the compare value on a count enable, the channel sets a sticky match flag. Depending on its mode, the counter then either clears to zero or keeps running. A free-running counter that wraps from all ones sets an overflow flag. A match can raise a level interrupt or a one-cycle DMA request.

A counter write is held back and lands on the counter only after two reference edges. Software therefore sees the old running count for a short while. A parameter mask marks which channel slots physically exist.

Top module: `match_timer`

## Requirements
- R1: After reset the run register, every control/status word and every counter read 0, every compare register reads 0xFFFFFFFF, and all `irqOut` and `dmaReq` bits are low.
- R2: The address map is as follows. The run register is at byte 0x000. Channel n occupies 0x10+0x10*n, with control/status at +0x0, counter at +0x4 and compare at +0x8. A compare write is visible on the next read. Unmapped or unaligned addresses read 0 and ignore writes.
- R3: Bit n of the run register enables counting of channel n. A write to the run register replaces all its bits. A channel whose run bit is 0 holds its count.
- R4: Control/status bits 2:0 pick the count rate: 4 counts every 8th synchronised reference rising edge, 5 every 32nd, 6 every 128th, 7 every edge, and 0 to 3 stop counting. One prescaler is shared by all channels.
- R5: With control/status bit 8 = 1 (clear mode), a count enable that finds counter == compare loads 0 into the counter and sets the match flag, bit 15.
- R6: With bit 8 = 0 (free mode), the counter increments on every count enable. Equality with compare sets bit 15. A count enable at 0xFFFFFFFF wraps the counter to 0 and sets the overflow flag, bit 14.
- R7: Writing 0 to bit 15 or bit 14 clears that flag, and writing 1 leaves it unchanged. A flag set in the same cycle as a clearing write wins. Only bits 15, 14, 8, 7, 5:4 and 2:0 read back; all other bits read 0.
- R8: `irqOut[n]` is high exactly while channel n's bit 15 is set and bits 5:4 equal 2'b10.
- R9: `dmaReq[n]` is high for one bus cycle, in the cycle bit 15 goes from 0 to 1, when bits 5:4 equal 2'b01. Request type 2'b00 drives neither output.
- R10: A counter write is loaded on the second synchronised reference edge after it, and a newer write restarts that wait. Until the load, reads return the running old count. The load cycle performs no count and no match.
- R11: Channels whose `CH_MASK` bit is 0 read 0 at all their addresses and ignore writes. Their run bits read 0, and their `irqOut`/`dmaReq` bits stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Asynchronous active-low reset |
| refClk | input | 1 | Slow reference clock, asynchronous to `clk` |
| busAddr | input | ADDR_W | Byte address of the register access |
| busWr | input | 1 | Write strobe, one cycle per write |
| busWdata | input | CNT_W | Write data |
| busRdata | output | CNT_W | Read data for `busAddr`, combinational |
| irqOut | output | NUM_CH | Per-channel match interrupt level |
| dmaReq | output | NUM_CH | Per-channel match DMA request pulse |

## Verification
The assertions take for granted that the reference clock is at least three bus cycles per half period. This keeps synchronised edges apart, so the prescaler steps at most once per edge. They also assume that each register access uses a word-aligned address held for a full cycle. The bench toggles the reference clock every three bus cycles and drives the bus only a delay after the rising bus edge. It also stops a channel, or picks quiet moments, before rewriting a control word whose flags it then checks. A behavioural model tracks the flags and counts every cycle and compares the read port and both request outputs.

// File: rtl/mt_pkg.sv
package mt_pkg;
  localparam int BIT_MATCH = 15;
  localparam int BIT_OVF   = 14;
  localparam int BIT_CLR   = 8;
  localparam int BIT_IE    = 7;

  typedef enum logic [1:0] {
    REQ_NONE = 2'b00,
    REQ_DMA  = 2'b01,
    REQ_IRQ  = 2'b10,
    REQ_RSVD = 2'b11
  } reqType_e;

  // strobes from the control block to one channel datapath
  typedef struct packed {
    logic wrCsr;
    logic wrCnt;
    logic wrCor;
    logic run;
    logic tickRef;
    logic tickDiv8;
    logic tickDiv32;
    logic tickDiv128;
  } chanCtl_t;
endpackage

// File: rtl/mt_ctrl.sv
module mt_ctrl
  import mt_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter logic [NUM_CH-1:0] CH_MASK = '1,
  parameter int CNT_W = 32,
  parameter int ADDR_W = 12
) (
  input  logic clk,
  input  logic rstN,
  input  logic refClk,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic busWr,
  input  logic [CNT_W-1:0] busWdata,
  output logic [CNT_W-1:0] busRdata,
  input  logic [NUM_CH-1:0][15:0] chCsr,
  input  logic [NUM_CH-1:0][CNT_W-1:0] chCnt,
  input  logic [NUM_CH-1:0][CNT_W-1:0] chCor,
  output chanCtl_t [NUM_CH-1:0] ctl
);
  localparam int DIV_A = 8;
  localparam int DIV_B = 32;
  localparam int DIV_C = 128;
  localparam int DA_W  = $clog2(DIV_A);
  localparam int DB_W  = $clog2(DIV_B);
  localparam int PRE_W = $clog2(DIV_C);
  localparam int BLK_W = ADDR_W - 4;
  localparam int SYNC_N = 3;

  logic [SYNC_N-1:0] refSync;
  logic refTick;
  logic [PRE_W-1:0] preCnt;
  logic [NUM_CH-1:0] runReg;
  logic aligned, selRun;
  logic [BLK_W-1:0] blockIdx;
  logic [1:0] regSel;
  logic tick8, tick32, tick128;

  // two-stage synchroniser plus one stage for edge detection
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) refSync <= '0;
    else refSync <= {refSync[SYNC_N-2:0], refClk};
  end
  assign refTick = refSync[1] & ~refSync[2];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) preCnt <= '0;
    else if (refTick) preCnt <= preCnt + PRE_W'(1);
  end
  assign tick8   = refTick & (&preCnt[DA_W-1:0]);
  assign tick32  = refTick & (&preCnt[DB_W-1:0]);
  assign tick128 = refTick & (&preCnt);

  assign aligned  = (busAddr[1:0] == 2'b00);
  assign blockIdx = busAddr[ADDR_W-1:4];
  assign regSel   = busAddr[3:2];
  assign selRun   = aligned && (busAddr[ADDR_W-1:2] == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) runReg <= '0;
    else if (busWr && selRun) runReg <= busWdata[NUM_CH-1:0] & CH_MASK;
  end

  always_comb begin
    for (int i = 0; i < NUM_CH; i++) begin
      logic hit;
      hit = aligned && CH_MASK[i] && (blockIdx == BLK_W'(i + 1));
      ctl[i].wrCsr      = busWr && hit && (regSel == 2'd0);
      ctl[i].wrCnt      = busWr && hit && (regSel == 2'd1);
      ctl[i].wrCor      = busWr && hit && (regSel == 2'd2);
      ctl[i].run        = runReg[i];
      ctl[i].tickRef    = refTick;
      ctl[i].tickDiv8   = tick8;
      ctl[i].tickDiv32  = tick32;
      ctl[i].tickDiv128 = tick128;
    end
  end

  always_comb begin
    busRdata = '0;
    if (selRun) busRdata = CNT_W'(runReg);
    for (int i = 0; i < NUM_CH; i++) begin
      if (aligned && CH_MASK[i] && (blockIdx == BLK_W'(i + 1))) begin
        case (regSel)
          2'd0: busRdata = CNT_W'(chCsr[i]);
          2'd1: busRdata = chCnt[i];
          2'd2: busRdata = chCor[i];
          default: busRdata = '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/mt_chan.sv
module mt_chan
  import mt_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic clk,
  input  logic rstN,
  input  chanCtl_t ctl,
  input  logic [CNT_W-1:0] wdata,
  output logic [15:0] csrOut,
  output logic [CNT_W-1:0] cntOut,
  output logic [CNT_W-1:0] corOut,
  output logic irq,
  output logic dma
);
  localparam int PEND_W = 2;
  localparam logic [PEND_W-1:0] PEND_START = PEND_W'(2);

  logic [CNT_W-1:0] cnt, cor, pendVal, cntNext;
  logic [PEND_W-1:0] pendCnt;
  logic flagMatch, flagOvf, clrMode, ieBit, dmaQ;
  reqType_e reqType;
  logic [2:0] clkSel;
  logic selTick, countEn, loadNow, atCompare, atTop, setMatch, setOvf;

  always_comb begin
    case (clkSel)
      3'd4: selTick = ctl.tickDiv8;
      3'd5: selTick = ctl.tickDiv32;
      3'd6: selTick = ctl.tickDiv128;
      3'd7: selTick = ctl.tickRef;
      default: selTick = 1'b0;
    endcase
  end

  assign countEn   = ctl.run & selTick;
  assign loadNow   = (pendCnt == PEND_W'(1)) & ctl.tickRef & ~ctl.wrCnt;
  assign atCompare = (cnt == cor);
  assign atTop     = &cnt;
  assign setMatch  = countEn & ~loadNow & atCompare;
  assign setOvf    = countEn & ~loadNow & ~clrMode & atTop;

  always_comb begin
    cntNext = cnt;
    if (loadNow) cntNext = pendVal;
    else if (countEn) cntNext = (clrMode && atCompare) ? '0 : cnt + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt     <= '0;
      cor     <= '1;
      pendVal <= '0;
      pendCnt <= '0;
    end else begin
      cnt <= cntNext;
      if (ctl.wrCor) cor <= wdata;
      if (ctl.wrCnt) begin
        pendVal <= wdata;
        pendCnt <= PEND_START;
      end else if (ctl.tickRef && pendCnt != '0) begin
        pendCnt <= pendCnt - PEND_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flagMatch <= 1'b0;
      flagOvf   <= 1'b0;
      clrMode   <= 1'b0;
      ieBit     <= 1'b0;
      reqType   <= REQ_NONE;
      clkSel    <= '0;
      dmaQ      <= 1'b0;
    end else begin
      flagMatch <= (ctl.wrCsr ? (flagMatch & wdata[BIT_MATCH]) : flagMatch) | setMatch;
      flagOvf   <= (ctl.wrCsr ? (flagOvf & wdata[BIT_OVF]) : flagOvf) | setOvf;
      dmaQ      <= setMatch & ~flagMatch & (reqType == REQ_DMA);
      if (ctl.wrCsr) begin
        clrMode <= wdata[BIT_CLR];
        ieBit   <= wdata[BIT_IE];
        reqType <= reqType_e'(wdata[5:4]);
        clkSel  <= wdata[2:0];
      end
    end
  end

  assign csrOut = {flagMatch, flagOvf, 5'b0, clrMode, ieBit, 1'b0, reqType, 1'b0, clkSel};
  assign cntOut = cnt;
  assign corOut = cor;
  assign irq    = flagMatch & (reqType == REQ_IRQ);
  assign dma    = dmaQ;
endmodule

// File: rtl/match_timer.sv
module match_timer
  import mt_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter logic [NUM_CH-1:0] CH_MASK = 4'b1011,
  parameter int CNT_W = 32,
  parameter int ADDR_W = 12
) (
  input  logic clk,
  input  logic rstN,
  input  logic refClk,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic busWr,
  input  logic [CNT_W-1:0] busWdata,
  output logic [CNT_W-1:0] busRdata,
  output logic [NUM_CH-1:0] irqOut,
  output logic [NUM_CH-1:0] dmaReq
);
  chanCtl_t [NUM_CH-1:0] ctlBus;
  logic [NUM_CH-1:0][15:0] chCsr;
  logic [NUM_CH-1:0][CNT_W-1:0] chCnt;
  logic [NUM_CH-1:0][CNT_W-1:0] chCor;

  mt_ctrl #(.NUM_CH(NUM_CH), .CH_MASK(CH_MASK), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .refClk(refClk),
    .busAddr(busAddr), .busWr(busWr), .busWdata(busWdata), .busRdata(busRdata),
    .chCsr(chCsr), .chCnt(chCnt), .chCor(chCor), .ctl(ctlBus)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    if (CH_MASK[g]) begin : g_present
      mt_chan #(.CNT_W(CNT_W)) u_chan (
        .clk(clk), .rstN(rstN), .ctl(ctlBus[g]), .wdata(busWdata),
        .csrOut(chCsr[g]), .cntOut(chCnt[g]), .corOut(chCor[g]),
        .irq(irqOut[g]), .dma(dmaReq[g])
      );
    end else begin : g_absent
      assign chCsr[g]  = '0;
      assign chCnt[g]  = '0;
      assign chCor[g]  = '0;
      assign irqOut[g] = 1'b0;
      assign dmaReq[g] = 1'b0;
    end
  end
endmodule

// File: rtl/mt_checker.sv
module mt_checker
  import mt_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter logic [NUM_CH-1:0] CH_MASK = '1,
  parameter int CNT_W = 32,
  parameter int ADDR_W = 12
) (
  input logic clk,
  input logic rstN,
  input logic [ADDR_W-1:0] busAddr,
  input logic [CNT_W-1:0] busRdata,
  input logic [NUM_CH-1:0] irqOut,
  input logic [NUM_CH-1:0] dmaReq,
  input logic [NUM_CH-1:0][15:0] chCsr,
  input logic [NUM_CH-1:0][CNT_W-1:0] chCnt,
  input chanCtl_t [NUM_CH-1:0] ctl
);
  p_absent_quiet_r11: assert property (@(posedge clk) disable iff (!rstN)
    ((irqOut | dmaReq) & ~CH_MASK) == '0);

  p_run_readback_r11: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr == '0) |-> ((busRdata[NUM_CH-1:0] & ~CH_MASK) == '0));

  for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
    p_dma_pulse_r9: assert property (@(posedge clk) disable iff (!rstN)
      dmaReq[i] |=> !dmaReq[i]);

    p_irq_dma_excl_r8: assert property (@(posedge clk) disable iff (!rstN)
      !(irqOut[i] && dmaReq[i]));

    p_irq_flag_r8: assert property (@(posedge clk) disable iff (!rstN)
      irqOut[i] |-> chCsr[i][BIT_MATCH]);

    p_hold_stopped_r3: assert property (@(posedge clk) disable iff (!rstN)
      (!ctl[i].run && !ctl[i].tickRef) |=> $stable(chCnt[i]));

    p_match_sticky_r7: assert property (@(posedge clk) disable iff (!rstN)
      (chCsr[i][BIT_MATCH] && !ctl[i].wrCsr) |=> chCsr[i][BIT_MATCH]);

    p_ovf_sticky_r7: assert property (@(posedge clk) disable iff (!rstN)
      (chCsr[i][BIT_OVF] && !ctl[i].wrCsr) |=> chCsr[i][BIT_OVF]);

    p_tick_nest_r4: assert property (@(posedge clk) disable iff (!rstN)
      (ctl[i].tickDiv128 |-> ctl[i].tickDiv32) and (ctl[i].tickDiv32 |-> ctl[i].tickDiv8)
      and (ctl[i].tickDiv8 |-> ctl[i].tickRef));

    p_strobe_onehot_r2: assert property (@(posedge clk) disable iff (!rstN)
      $onehot0({ctl[i].wrCsr, ctl[i].wrCnt, ctl[i].wrCor}));

    p_load_deferred_r10: assert property (@(posedge clk) disable iff (!rstN)
      (ctl[i].wrCnt && !ctl[i].run) |=> $stable(chCnt[i]));
  end
endmodule

bind match_timer mt_checker #(
  .NUM_CH(NUM_CH), .CH_MASK(CH_MASK), .CNT_W(CNT_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .busRdata(busRdata),
  .irqOut(irqOut), .dmaReq(dmaReq), .chCsr(chCsr), .chCnt(chCnt), .ctl(ctlBus)
);

// File: tb/match_timer_tb.sv
`timescale 1ns/1ps
module match_timer_tb;
  localparam int NUM_CH = 4;
  localparam logic [NUM_CH-1:0] CH_MASK = 4'b1011;
  localparam int CNT_W = 32;
  localparam int ADDR_W = 12;
  localparam int REF_HALF = 3;
  localparam logic [15:0] CSR_RW = 16'h01B7;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic refClk = 1'b0;
  logic [ADDR_W-1:0] busAddr = '0;
  logic busWr = 1'b0;
  logic [CNT_W-1:0] busWdata = '0;
  logic [CNT_W-1:0] busRdata;
  logic [NUM_CH-1:0] irqOut, dmaReq;

  int checks = 0;
  int fails = 0;
  int dmaSeen = 0;
  bit done = 0;

  always #2 clk = ~clk;

  match_timer #(.NUM_CH(NUM_CH), .CH_MASK(CH_MASK), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_dut (
    .clk(clk), .rstN(rstN), .refClk(refClk), .busAddr(busAddr), .busWr(busWr),
    .busWdata(busWdata), .busRdata(busRdata), .irqOut(irqOut), .dmaReq(dmaReq)
  );

  // reference clock, changed away from bus clock edges
  initial begin
    forever begin
      repeat (REF_HALF) @(posedge clk);
      #1 refClk = ~refClk;
    end
  end

  // ---------------- behavioural reference model ----------------
  logic [31:0] mCnt [NUM_CH];
  logic [31:0] mCor [NUM_CH];
  logic [31:0] mPendVal [NUM_CH];
  int mPend [NUM_CH];
  logic [15:0] mCsr [NUM_CH];
  logic [NUM_CH-1:0] mRun, mDma;
  int mPre;
  bit refHist[$];

  function automatic logic [31:0] mRead(logic [ADDR_W-1:0] a);
    int blk;
    if (a[1:0] != 2'b00) return 32'h0;
    if (a[ADDR_W-1:2] == 0) return 32'(mRun);
    blk = int'(a[ADDR_W-1:4]);
    if (blk >= 1 && blk <= NUM_CH && CH_MASK[blk-1]) begin
      case (a[3:2])
        2'd0: return 32'(mCsr[blk-1]);
        2'd1: return mCnt[blk-1];
        2'd2: return mCor[blk-1];
        default: return 32'h0;
      endcase
    end
    return 32'h0;
  endfunction

  always @(posedge clk) begin : model
    bit tick, t8, t32, t128, selT, ce, ld, sm, so, wCsr, wCnt, wCor, f15, f14;
    logic [31:0] nxt;
    logic [NUM_CH-1:0] dmaN;
    if (!rstN) begin
      for (int c = 0; c < NUM_CH; c++) begin
        mCnt[c] = 0; mCor[c] = 32'hFFFF_FFFF; mPendVal[c] = 0; mPend[c] = 0; mCsr[c] = 0;
      end
      mRun = 0; mDma = 0; mPre = 0;
      refHist = '{0, 0, 0};
    end else begin
      tick = refHist[1] && !refHist[2];
      t8   = tick && (mPre % 8 == 7);
      t32  = tick && (mPre % 32 == 31);
      t128 = tick && (mPre % 128 == 127);
      dmaN = '0;
      for (int c = 0; c < NUM_CH; c++) begin
        if (CH_MASK[c]) begin
          wCsr = busWr && (busAddr == ADDR_W'(16 + 16 * c));
          wCnt = busWr && (busAddr == ADDR_W'(20 + 16 * c));
          wCor = busWr && (busAddr == ADDR_W'(24 + 16 * c));
          case (mCsr[c][2:0])
            3'd4: selT = t8;
            3'd5: selT = t32;
            3'd6: selT = t128;
            3'd7: selT = tick;
            default: selT = 0;
          endcase
          ce = mRun[c] && selT;
          ld = (mPend[c] == 1) && tick && !wCnt;
          sm = 0; so = 0; nxt = mCnt[c];
          if (ld) nxt = mPendVal[c];
          else if (ce) begin
            if (mCsr[c][8] && mCnt[c] == mCor[c]) begin nxt = 0; sm = 1; end
            else begin
              if (mCnt[c] == mCor[c]) sm = 1;
              if (!mCsr[c][8] && mCnt[c] == 32'hFFFF_FFFF) so = 1;
              nxt = mCnt[c] + 1;
            end
          end
          if (wCnt) begin mPendVal[c] = busWdata; mPend[c] = 2; end
          else if (tick && mPend[c] != 0) mPend[c] = mPend[c] - 1;
          if (wCor) mCor[c] = busWdata;
          dmaN[c] = sm && !mCsr[c][15] && (mCsr[c][5:4] == 2'b01);
          f15 = (wCsr ? (mCsr[c][15] && busWdata[15]) : mCsr[c][15]) || sm;
          f14 = (wCsr ? (mCsr[c][14] && busWdata[14]) : mCsr[c][14]) || so;
          mCsr[c] = {f15, f14, 14'b0} | ((wCsr ? busWdata[15:0] : mCsr[c]) & CSR_RW);
          mCnt[c] = nxt;
        end
      end
      if (busWr && busAddr == '0) mRun = busWdata[NUM_CH-1:0] & CH_MASK;
      mDma = dmaN;
      mPre = (mPre + (tick ? 1 : 0)) % 128;
      refHist.push_front(refClk);
      void'(refHist.pop_back());
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin : compare
    logic [31:0] er;
    if (rstN && !done) begin
      for (int c = 0; c < NUM_CH; c++) begin
        checks++;
        if (irqOut[c] !== (CH_MASK[c] && mCsr[c][15] && mCsr[c][5:4] == 2'b10)) begin
          fails++;
          $display("FAIL R8 irqOut[%0d] actual=%0b expected=%0b", c, irqOut[c], !irqOut[c]);
        end
        checks++;
        if (dmaReq[c] !== mDma[c]) begin
          fails++;
          $display("FAIL R9 dmaReq[%0d] actual=%0b expected=%0b", c, dmaReq[c], mDma[c]);
        end
      end
      er = mRead(busAddr);
      checks++;
      if (busRdata !== er) begin
        fails++;
        $display("FAIL R2 read addr=%h actual=%h expected=%h", busAddr, busRdata, er);
      end
      if (dmaReq[1]) dmaSeen++;
    end
  end

  // ---------------- helpers ----------------
  task automatic idle(int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic busWrite(logic [ADDR_W-1:0] a, logic [31:0] d);
    @(posedge clk); #1;
    busAddr = a; busWr = 1'b1; busWdata = d;
    @(posedge clk); #1;
    busWr = 1'b0;
  endtask

  task automatic busRead(logic [ADDR_W-1:0] a, output logic [31:0] d);
    @(posedge clk); #1;
    busAddr = a;
    @(negedge clk);
    d = busRdata;
  endtask

  task automatic checkEq(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // ---------------- directed flow ----------------
  initial begin : flow
    logic [31:0] v, w;
    idle(5);
    #1 rstN = 1'b1;

    // R1 reset values
    busRead(12'h000, v); checkEq("R1 run reg", v, 32'h0);
    busRead(12'h010, v); checkEq("R1 csr0", v, 32'h0);
    busRead(12'h014, v); checkEq("R1 cnt0", v, 32'h0);
    busRead(12'h018, v); checkEq("R1 cor0", v, 32'hFFFF_FFFF);
    checkEq("R1 irq/dma", {28'h0, irqOut | dmaReq}, 32'h0);

    // R2 map, immediate compare write, unmapped and unaligned
    busWrite(12'h028, 32'h0000_1234);
    busRead(12'h028, v); checkEq("R2 cor1 write", v, 32'h0000_1234);
    busRead(12'h00C, v); checkEq("R2 unmapped", v, 32'h0);
    busRead(12'h058, v); checkEq("R2 beyond channels", v, 32'h0);
    busRead(12'h02A, v); checkEq("R2 unaligned", v, 32'h0);

    // R11 absent channel 2
    busWrite(12'h038, 32'h5);
    busRead(12'h038, v); checkEq("R11 absent cor", v, 32'h0);
    busWrite(12'h030, 32'h01B7);
    busRead(12'h030, v); checkEq("R11 absent csr", v, 32'h0);
    busWrite(12'h000, 32'hF);
    busRead(12'h000, v); checkEq("R11 run bits", v, 32'hB);
    busWrite(12'h000, 32'h0);

    // R7 readback mask, writing 1 to clear flags keeps them 0
    busWrite(12'h010, 32'hFFFF);
    busRead(12'h010, v); checkEq("R7 csr mask", v, 32'h01B7);
    busWrite(12'h010, 32'h0);

    // R10 deferred counter write
    busWrite(12'h014, 32'd100);
    busRead(12'h014, v); checkEq("R10 old count before load", v, 32'h0);
    idle(20);
    busRead(12'h014, v); checkEq("R10 loaded count", v, 32'd100);

    // R5 clear mode with interrupt request
    busWrite(12'h014, 32'd0);
    idle(20);
    busWrite(12'h018, 32'd5);
    busWrite(12'h010, 32'h0127);
    busWrite(12'h000, 32'h1);
    idle(100);
    busRead(12'h010, v); checkEq("R5 match flag", v & 32'h8000, 32'h8000);
    checkEq("R8 irq high", {31'h0, irqOut[0]}, 32'h1);
    busRead(12'h014, v); checkEq("R5 count bounded by compare", {31'h0, v <= 32'd5}, 32'h1);
    busWrite(12'h000, 32'h0);
    busWrite(12'h010, 32'h0127);
    busRead(12'h010, v); checkEq("R7 flag cleared by zero", v, 32'h0127);
    checkEq("R8 irq low", {31'h0, irqOut[0]}, 32'h0);
    busWrite(12'h010, 32'h8127);
    busRead(12'h010, v); checkEq("R7 one keeps flag", v, 32'h0127);

    // R6/R9 free mode, wrap overflow, DMA request
    busWrite(12'h024, 32'hFFFF_FFF0);
    idle(20);
    busWrite(12'h028, 32'd3);
    busWrite(12'h020, 32'h0017);
    busWrite(12'h000, 32'h2);
    idle(300);
    busRead(12'h020, v); checkEq("R6 match and overflow flags", v, 32'hC017);
    busRead(12'h024, v); checkEq("R6 keeps counting past compare", {31'h0, v > 32'd3}, 32'h1);
    checkEq("R9 single dma pulse", 32'(dmaSeen), 32'd1);
    busWrite(12'h000, 32'h0);
    busWrite(12'h020, 32'h0017);
    busRead(12'h020, v); checkEq("R7 both flags cleared", v, 32'h0017);

    // R4 rate selection on channel 3
    busWrite(12'h040, 32'h0006);
    busWrite(12'h000, 32'h8);
    idle(1600);
    busRead(12'h044, v); checkEq("R4 div128 count range", {31'h0, (v >= 1) && (v <= 3)}, 32'h1);
    busWrite(12'h040, 32'h0005);
    idle(600);
    busWrite(12'h040, 32'h0004);
    idle(480);
    busWrite(12'h040, 32'h0000);
    busRead(12'h044, v);
    idle(200);
    busRead(12'h044, w); checkEq("R4 select 0 stops", w, v);

    // R3 run bit gating, R10 write while running
    busWrite(12'h040, 32'h0007);
    busWrite(12'h000, 32'h0);
    busRead(12'h044, v);
    idle(100);
    busRead(12'h044, w); checkEq("R3 stopped holds", w, v);
    busWrite(12'h000, 32'h8);
    idle(60);
    busRead(12'h044, w); checkEq("R3 running advances", {31'h0, w > v}, 32'h1);
    busWrite(12'h044, 32'd1000);
    idle(30);
    busRead(12'h044, w); checkEq("R10 load while running", {31'h0, w >= 32'd1000 && w < 32'd1010}, 32'h1);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule